// File: doc/BRIEF.md
# Legacy Memory Window Address Mapper

This block sits between a processor-side request port and a set of region memories. It takes a 20-bit real-mode physical address and decides which region serves it: main RAM, the option ROM, the video frame buffer window, or a local source inside the mapper. It also works out the offset into that region. The local source covers fixed identification bytes near the top of the address space and video accesses that are absorbed while VGA emulation is on.

A request carries a size (byte, word or dword), a write flag and write data. The mapper registers a translated response one cycle later. The response holds the target, the offset, a write enable for the backend, the forwarded write data and the little-endian read data for locally served bytes. The ROM upper limit, the RAM size and the emulation switch are configuration inputs. An address beyond the configured RAM raises a halt flag that stays set until reset.

Top module: `lwm_mapper`

## Requirements
- R1: When no higher-priority rule applies, an address from 0xC0000 through `cfg_rom_limit` inclusive gives target ROM (code 1) with offset address minus 0xC0000.
- R2: An address above `cfg_rom_limit` and below 0xD0000 gives target RAM (code 0) with offset 0, and does not set halt.
- R3: With emulation off, an address from 0xA0000 to 0xBFFFF gives target VIDEO (code 2) with offset address minus 0xA0000, and writes are forwarded (`rsp_we` = 1).
- R4: With `cfg_vga_emu` = 1, any access from 0xA0000 to 0xBFFFF gives target LOCAL (code 3), read data 0 at every size, and `rsp_we` = 0.
- R5: Addresses 0xFFFF5 through 0xFFFFF give target LOCAL with offset address minus 0xFFFF5. Their bytes, in ascending address order, are the ASCII text 08/14/99, then 0x00, then the model byte 0xFC, then the submodel byte 0x00.
- R6: Local read data is little-endian: byte lane i holds the identification byte at address+i. Size code 0 is a byte, 1 a word and 2 a dword. Lanes beyond the size, and lanes past 0xFFFFF, read 0.
- R7: Writes that target LOCAL never reach a backend (`rsp_we` = 0).
- R8: An address that is at least `cfg_ram_size` and matches no earlier rule gives target RAM with offset 0 and sets `halt`.
- R9: Any other address gives target RAM with offset equal to the address, and `rsp_we` equal to the request's write flag.
- R10: The rules apply in a fixed priority: absorbed video, then ROM, then the suspect gap, then video, then identification bytes, then RAM overflow, then plain RAM. For example, a ROM limit of 0xFFFFF makes 0xFFFFE a ROM address.
- R11: `rsp_valid` rises exactly one cycle after each `req_valid`, and `halt` stays set until reset.
- R12: After reset, `rsp_valid`, `rsp_we` and `halt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_addr | input | 20 | Physical address |
| req_wdata | input | 32 | Write data, little-endian |
| cfg_rom_limit | input | 20 | Last address of the option ROM window |
| cfg_ram_size | input | 21 | RAM size in bytes |
| cfg_vga_emu | input | 1 | Absorb video window accesses |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_tgt | output | 2 | 0 RAM, 1 ROM, 2 VIDEO, 3 LOCAL |
| rsp_offset | output | 20 | Offset inside the target |
| rsp_we | output | 1 | Write enable towards the backend |
| rsp_size | output | 2 | Forwarded size |
| rsp_wdata | output | 32 | Forwarded write data |
| rsp_rdata | output | 32 | Locally served read data |
| halt | output | 1 | Sticky RAM overflow flag |

## Verification
A wrong priority or a wrong range comparison inside the decoder shows up on the very next response as a wrong target code or offset. A fault in the identification table or in the lane masking shows up as wrong bytes in `rsp_rdata` on the same response. A halt latch that clears or sets wrongly shows on `halt` one cycle after the offending or following request. Random addresses are biased toward the region edges, and the sizes are mixed so that lanes cross the 0xFFFFF boundary.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  typedef enum logic [1:0] {
    TGT_RAM   = 2'd0,
    TGT_ROM   = 2'd1,
    TGT_VIDEO = 2'd2,
    TGT_LOCAL = 2'd3
  } tgt_e;

  localparam int IDENT_COUNT = 11;

  // identification bytes, index 0 is the lowest address
  function automatic logic [7:0] ident_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:  b = 8'h30;
      4'd1:  b = 8'h38;
      4'd2:  b = 8'h2F;
      4'd3:  b = 8'h31;
      4'd4:  b = 8'h34;
      4'd5:  b = 8'h2F;
      4'd6:  b = 8'h39;
      4'd7:  b = 8'h39;
      4'd9:  b = 8'hFC;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lwm_decode.sv
module lwm_decode
  import lwm_pkg::*;
#(
  parameter int AW = 20,
  parameter logic [AW-1:0] ROM_BASE    = 20'hC0000,
  parameter logic [AW-1:0] SUSPECT_END = 20'hD0000,
  parameter logic [AW-1:0] VID_BASE    = 20'hA0000,
  parameter logic [AW-1:0] VID_LAST    = 20'hBFFFF,
  parameter logic [AW-1:0] ID_BASE     = 20'hFFFF5
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] rom_limit,
  input  logic [AW:0]   ram_size,
  input  logic          vga_emu,
  output tgt_e          tgt,
  output logic [AW-1:0] offset,
  output logic          is_id,
  output logic          ovf
);
  logic in_video, absorb;

  assign in_video = (addr >= VID_BASE) && (addr <= VID_LAST);
  assign absorb   = vga_emu && in_video;

  always_comb begin
    tgt    = TGT_RAM;
    offset = addr;
    is_id  = 1'b0;
    ovf    = 1'b0;
    if (absorb) begin
      tgt    = TGT_LOCAL;
      offset = '0;
    end else if (addr >= ROM_BASE && addr <= rom_limit) begin
      tgt    = TGT_ROM;
      offset = addr - ROM_BASE;
    end else if (addr > rom_limit && addr < SUSPECT_END) begin
      offset = '0;
    end else if (in_video) begin
      tgt    = TGT_VIDEO;
      offset = addr - VID_BASE;
    end else if (addr >= ID_BASE) begin
      tgt    = TGT_LOCAL;
      offset = addr - ID_BASE;
      is_id  = 1'b1;
    end else if ({1'b0, addr} >= ram_size) begin
      offset = '0;
      ovf    = 1'b1;
    end
  end
endmodule

// File: rtl/lwm_ident.sv
module lwm_ident
  import lwm_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter logic [AW-1:0] ID_BASE = 20'hFFFF5
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          en,
  output logic [DW-1:0] data
);
  localparam int NB = DW / 8;

  genvar i;
  generate
    for (i = 0; i < NB; i++) begin : g_lane
      logic [AW:0] lane_addr;
      logic [AW:0] lane_idx;
      logic        lane_on;
      assign lane_addr = {1'b0, addr} + (AW+1)'(i);
      assign lane_idx  = lane_addr - {1'b0, ID_BASE};
      assign lane_on   = en && (i < (1 << size)) && !lane_addr[AW]
                         && (lane_addr >= {1'b0, ID_BASE});
      assign data[8*i +: 8] = lane_on ? ident_byte(lane_idx[3:0]) : 8'h00;
    end
  endgenerate
endmodule

// File: rtl/lwm_mapper.sv
module lwm_mapper
  import lwm_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter logic [AW-1:0] ROM_BASE    = 20'hC0000,
  parameter logic [AW-1:0] SUSPECT_END = 20'hD0000,
  parameter logic [AW-1:0] VID_BASE    = 20'hA0000,
  parameter logic [AW-1:0] VID_LAST    = 20'hBFFFF,
  parameter logic [AW-1:0] ID_BASE     = 20'hFFFF5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [AW-1:0] cfg_rom_limit,
  input  logic [AW:0]   cfg_ram_size,
  input  logic          cfg_vga_emu,
  output logic          rsp_valid,
  output logic [1:0]    rsp_tgt,
  output logic [AW-1:0] rsp_offset,
  output logic          rsp_we,
  output logic [1:0]    rsp_size,
  output logic [DW-1:0] rsp_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          halt
);
  tgt_e          d_tgt;
  logic [AW-1:0] d_off;
  logic          d_id, d_ovf;
  logic [DW-1:0] d_ldata;

  lwm_decode #(
    .AW(AW), .ROM_BASE(ROM_BASE), .SUSPECT_END(SUSPECT_END),
    .VID_BASE(VID_BASE), .VID_LAST(VID_LAST), .ID_BASE(ID_BASE)
  ) u_decode (
    .addr(req_addr), .rom_limit(cfg_rom_limit), .ram_size(cfg_ram_size),
    .vga_emu(cfg_vga_emu), .tgt(d_tgt), .offset(d_off), .is_id(d_id), .ovf(d_ovf)
  );

  lwm_ident #(.AW(AW), .DW(DW), .ID_BASE(ID_BASE)) u_ident (
    .addr(req_addr), .size(req_size), .en(d_id), .data(d_ldata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_we     <= 1'b0;
      rsp_tgt    <= 2'd0;
      rsp_offset <= '0;
      rsp_size   <= 2'd0;
      rsp_wdata  <= '0;
      rsp_rdata  <= '0;
      halt       <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_we    <= req_valid && req_write && (d_tgt != TGT_LOCAL);
      if (req_valid) begin
        rsp_tgt    <= d_tgt;
        rsp_offset <= d_off;
        rsp_size   <= req_size;
        rsp_wdata  <= req_wdata;
        rsp_rdata  <= d_ldata;
        if (d_ovf) halt <= 1'b1;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt); // R11
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> $past(req_valid)); // R8
  AST_ABSORB_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && cfg_vga_emu && req_addr >= VID_BASE && req_addr <= VID_LAST)
    |-> (rsp_rdata == '0 && !rsp_we && rsp_tgt == 2'd3)); // R4
  AST_ROM_MAP: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && !cfg_vga_emu && req_addr >= ROM_BASE && req_addr <= cfg_rom_limit)
    |-> (rsp_tgt == 2'd1 && rsp_offset == $past(req_addr) - ROM_BASE)); // R1
  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_size == 2'd0) |-> (rsp_rdata[DW-1:8] == '0)); // R6
  AST_LOCAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && req_addr >= ID_BASE && cfg_rom_limit < ID_BASE)
    |-> !rsp_we); // R7
endmodule

// File: tb/lwm_mapper_tb.sv
module lwm_mapper_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [19:0] req_addr, cfg_rom_limit;
  logic [31:0] req_wdata;
  logic [20:0] cfg_ram_size;
  logic        cfg_vga_emu;
  logic        rsp_valid, rsp_we, halt;
  logic [1:0]  rsp_tgt, rsp_size;
  logic [19:0] rsp_offset;
  logic [31:0] rsp_wdata, rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit exp_halt = 0;

  always #2 clk = ~clk;

  lwm_mapper u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_rom_limit(cfg_rom_limit), .cfg_ram_size(cfg_ram_size),
    .cfg_vga_emu(cfg_vga_emu), .rsp_valid(rsp_valid), .rsp_tgt(rsp_tgt),
    .rsp_offset(rsp_offset), .rsp_we(rsp_we), .rsp_size(rsp_size),
    .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata), .halt(halt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_of(input int a);
    string s = "08/14/99";
    int k = a - 'hFFFF5;
    if (k < 0 || a > 'hFFFFF) return 8'h00;
    if (k < 8) return s[k];
    if (k == 9) return 8'hFC;
    return 8'h00;
  endfunction

  // expected translation from the requirements
  task automatic model(input int a, input int sz, output int tgt, output int off,
                       output bit idr, output bit ovf, output logic [31:0] ld);
    int lim = int'(cfg_rom_limit);
    idr = 0; ovf = 0; ld = 0;
    if (cfg_vga_emu && a >= 'hA0000 && a <= 'hBFFFF) begin tgt = 3; off = 0; end
    else if (a >= 'hC0000 && a <= lim) begin tgt = 1; off = a - 'hC0000; end
    else if (a > lim && a < 'hD0000) begin tgt = 0; off = 0; end
    else if (a >= 'hA0000 && a <= 'hBFFFF) begin tgt = 2; off = a - 'hA0000; end
    else if (a >= 'hFFFF5) begin tgt = 3; off = a - 'hFFFF5; idr = 1; end
    else if (a >= int'(cfg_ram_size)) begin tgt = 0; off = 0; ovf = 1; end
    else begin tgt = 0; off = a; end
    if (idr)
      for (int i = 0; i < (sz == 0 ? 1 : sz == 1 ? 2 : 4); i++)
        ld[8*i +: 8] = id_of(a + i);
  endtask

  task automatic access(input string req, input bit w, input int sz, input int a,
                        input logic [31:0] wd);
    int tgt, off; bit idr, ovf; logic [31:0] ld;
    model(a, sz, tgt, off, idr, ovf, ld);
    req_valid = 1; req_write = w; req_size = 2'(sz); req_addr = 20'(a); req_wdata = wd;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    if (ovf) exp_halt = 1;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " tgt"}, 64'(rsp_tgt), 64'(tgt));
    chk({req, " offset"}, 64'(rsp_offset), 64'(off));
    chk({req, " we"}, 64'(rsp_we), 64'(w && tgt != 3));
    chk({req, " rdata"}, 64'(rsp_rdata), 64'(ld));
    chk({req, " halt"}, 64'(halt), 64'(exp_halt));
    if (rsp_we) chk({req, " wdata"}, 64'(rsp_wdata), 64'(wd));
  endtask

  task automatic do_reset();
    rst = 1; req_valid = 0; exp_halt = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 valid", 64'(rsp_valid), 64'd0);
    chk("R12 we", 64'(rsp_we), 64'd0);
    chk("R12 halt", 64'(halt), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int a, sz;
    void'($urandom(32'd7));
    req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    cfg_rom_limit = 20'hC7FFF; cfg_ram_size = 21'h80000; cfg_vga_emu = 0;
    do_reset();
    access("R1 rom base", 0, 0, 'hC0000, 0);
    access("R1 rom limit", 1, 2, 'hC7FFF, 32'h11223344);
    access("R2 gap low", 0, 1, 'hC8000, 0);
    access("R2 gap high", 1, 0, 'hCFFFF, 32'h55);
    access("R3 video base", 1, 2, 'hA0000, 32'hCAFEF00D);
    access("R3 video last", 0, 0, 'hBFFFF, 0);
    cfg_vga_emu = 1;
    for (int s = 0; s < 3; s++) access("R4 absorb read", 0, s, 'hA1234, 0);
    access("R4 absorb write", 1, 2, 'hBFFFC, 32'hDEADBEEF);
    for (int k = 'hFFFF5; k <= 'hFFFFF; k++) access("R5 ident byte", 0, 0, k, 0);
    access("R6 word model", 0, 1, 'hFFFFE, 0);
    access("R6 dword date", 0, 2, 'hFFFF5, 0);
    access("R6 dword edge", 0, 2, 'hFFFFD, 0);
    access("R7 ident write", 1, 2, 'hFFFF6, 32'h01020304);
    access("R9 ram read", 0, 2, 'h12345, 0);
    access("R9 ram write", 1, 1, 'h7FFFF, 32'hABCD);
    cfg_rom_limit = 20'hFFFFF;
    access("R10 rom over ident", 0, 0, 'hFFFFE, 0);
    cfg_rom_limit = 20'hC7FFF;
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 6)
        0: a = 'hA0000 + $urandom % 'h20000;
        1: a = 'hC0000 + $urandom % 'h10000;
        2: a = 'hFFFF0 + $urandom % 16;
        3: a = 'h7FFF0 + $urandom % 32;
        default: a = $urandom % 'h100000;
      endcase
      sz = $urandom % 3;
      cfg_vga_emu = 1'($urandom % 2);
      cfg_rom_limit = 20'('hC0000 + $urandom % 'h10000);
      access("R9 random", 1'($urandom % 2), sz, a, $urandom);
    end
    cfg_rom_limit = 20'hC7FFF; cfg_ram_size = 21'h80000;
    do_reset();
    access("R8 overflow", 0, 0, 'h80000, 0);
    access("R11 halt sticky", 0, 0, 'h00010, 0);
    chk("R11 halt held", 64'(halt), 64'd1);
    do_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule